// File: doc/BRIEF.md
# Interrupt Source Coalescing State Machine

This block keeps a two-bit pending/queued state for each of a configurable number of interrupt sources. A pending bit P means the source has already sent one notification downstream and is waiting for its end-of-interrupt. A queued bit Q records that another trigger arrived while P was set. Repeated triggers are therefore folded into at most one outstanding notification per source. When the end-of-interrupt arrives, a recorded trigger re-fires the source.

Software reaches the state through a load/store port. Each source owns one page of 2^PAGE_SHIFT bytes. The source number sits in the address bits just above the page offset, and the top address bit selects an optional trigger page. Loads at fixed offsets either read a source's state or overwrite it. Every such load returns the state held before the access, and the read and the update happen as one step. When the options are enabled, a store at offset zero acts as end-of-interrupt, and any store to the trigger page triggers the source.

Hardware triggers arrive as one bit per source. Notifications leave as a one-cycle strobe carrying the source number. When several notifications are ready in the same cycle, they are sent one per cycle, lowest source number first.

Top module: `pq_coalesce`

## Requirements
- R1: After reset every source reads state 00, and both `evt_valid` and `bus_rvalid` are low.
- R2: A load at page offset 0x800 returns the current state without changing it. The state is in `bus_rdata` with P at bit 1 and Q at bit 0. With no bus request and no hardware trigger, no source's state changes.
- R3: Loads at page offsets 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11 respectively. Each returns the previous state, and `bus_rdata[63:2]` is always zero.
- R4: A trigger to a source whose P is clear sets P and leaves Q unchanged. In the cycle after the trigger, one `evt_valid` strobe carries that source's number, and P is set whenever an event is presented.
- R5: A trigger to a source whose P is set sets Q and sends no event.
- R6: A store at page offset 0 is an end-of-interrupt. With Q clear, the state becomes 00 and no event is sent. With Q set, the state becomes 10 and a new event is sent in the following cycle.
- R7: A store anywhere in a source's trigger page (top address bit set) acts as a trigger for that source.
- R8: A hardware trigger held high over many cycles sends exactly one event until the source receives an end-of-interrupt.
- R9: When a hardware trigger and a software access target the same source in the same cycle, the trigger is applied to the state left by the access. The load still returns the state from before the access.
- R10: Events ready in the same cycle are sent on consecutive cycles, lowest source number first.
- R11: A load at any other offset in the state page returns zero and changes no state.
- R12: Loads that overwrite the state never send an event, and they cancel an event not yet sent for that source.
- R13: `bus_rvalid` is high exactly in the cycle after each load request. `bus_rdata` is zero whenever `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_trig | input | NUM_SRC | Per-source hardware trigger, one event per high cycle |
| bus_req | input | 1 | Software access request, one cycle |
| bus_wr | input | 1 | 1 = store, 0 = load |
| bus_addr | input | PAGE_SHIFT+SRC_W+1 | {trigger-page select, source number, page offset} |
| bus_rdata | output | 64 | Load response; previous state in bits 1:0 |
| bus_rvalid | output | 1 | Load response valid, one cycle after the request |
| evt_valid | output | 1 | Event strobe toward the downstream queue |
| evt_src | output | SRC_W | Source number of the event |

## Verification
The hardest situations to reach from the ports are collisions. One is a software state overwrite and a hardware trigger landing on the same source in the same clock. Another is several sources becoming ready on one edge, so that the event serializer must order them. The bench drives both directly: it first forces a source to 11, then issues a clear-to-00 load together with that source's trigger bit, and separately raises three trigger bits in one cycle and follows the strobe on each later cycle. A trigger held high for several cycles then confirms that a pending source folds repeats into a single event.

// File: rtl/pq_pkg.sv
package pq_pkg;
   typedef enum logic [2:0] {
      OP_NONE,
      OP_GET,
      OP_SET,
      OP_EOI,
      OP_TRIG
   } pq_op_e;

   // s = {p, q, fwd}; apply one trigger event
   function automatic logic [2:0] pq_fire(input logic [2:0] s);
      if (!s[2]) return {1'b1, s[1], 1'b1};
      else       return {1'b1, 1'b1, s[0]};
   endfunction
endpackage

// File: rtl/pq_decode.sv
module pq_decode
   import pq_pkg::*;
#(
   parameter int NUM_SRC      = 8,
   parameter int PAGE_SHIFT   = 12,
   parameter bit STORE_EOI_EN = 1'b1,
   parameter bit TRIG_PAGE_EN = 1'b1,
   localparam int SRC_W       = $clog2(NUM_SRC),
   localparam int ADDR_W      = PAGE_SHIFT + SRC_W + 1
) (
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output pq_op_e            op,
   output logic [SRC_W-1:0]  src,
   output logic [1:0]        set_val
);
   localparam logic [PAGE_SHIFT-1:0] OFF_GET  = 'h800;
   localparam logic [PAGE_SHIFT-1:0] SET_BASE = 'hC00;
   localparam logic [PAGE_SHIFT-1:0] SET_MASK = 'h300;

   logic                  page_trig;
   logic [PAGE_SHIFT-1:0] off;
   logic                  src_ok, set_hit, eoi_ok, trig_ok;

   assign page_trig = bus_addr[ADDR_W-1];
   assign src       = bus_addr[PAGE_SHIFT +: SRC_W];
   assign off       = bus_addr[PAGE_SHIFT-1:0];
   assign src_ok    = ({1'b0, src} < (SRC_W+1)'(NUM_SRC));
   assign set_hit   = ((off & ~SET_MASK) == SET_BASE);
   assign set_val   = off[9:8];

   if (STORE_EOI_EN) begin : g_eoi_on
      assign eoi_ok = 1'b1;
   end else begin : g_eoi_off
      assign eoi_ok = 1'b0;
   end

   if (TRIG_PAGE_EN) begin : g_trig_on
      assign trig_ok = 1'b1;
   end else begin : g_trig_off
      assign trig_ok = 1'b0;
   end

   always_comb begin
      op = OP_NONE;
      if (bus_req && src_ok) begin
         if (!page_trig) begin
            if (!bus_wr) begin
               if (off == OFF_GET) op = OP_GET;
               else if (set_hit)   op = OP_SET;
            end else if (off == '0 && eoi_ok) begin
               op = OP_EOI;
            end
         end else if (bus_wr && trig_ok) begin
            op = OP_TRIG;
         end
      end
   end
endmodule

// File: rtl/pq_cell.sv
module pq_cell
   import pq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  pq_op_e     op,
   input  logic [1:0] set_val,
   input  logic       hw_trig,
   input  logic       emit_clr,
   output logic [1:0] pq,
   output logic       fwd
);
   logic [2:0] st_q, st_d;

   always_comb begin
      st_d    = st_q;
      st_d[0] = st_q[0] & ~emit_clr;
      if (sel) begin
         case (op)
            OP_SET:  st_d = {set_val, 1'b0};
            OP_EOI:  st_d = st_q[1] ? 3'b101 : 3'b000;
            OP_TRIG: st_d = pq_fire(st_d);
            default: ;
         endcase
      end
      if (hw_trig) st_d = pq_fire(st_d);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   assign pq  = st_q[2:1];
   assign fwd = st_q[0];
endmodule

// File: rtl/pq_pick.sv
module pq_pick #(
   parameter int NUM_SRC = 8,
   localparam int SRC_W  = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] fwd,
   output logic               valid,
   output logic [SRC_W-1:0]   idx,
   output logic [NUM_SRC-1:0] grant
);
   always_comb begin
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (fwd[i]) idx = SRC_W'(i);
      end
   end

   assign valid = |fwd;
   assign grant = valid ? (NUM_SRC'(1) << idx) : '0;
endmodule

// File: rtl/pq_coalesce.sv
module pq_coalesce
   import pq_pkg::*;
#(
   parameter int NUM_SRC      = 8,
   parameter int PAGE_SHIFT   = 12,
   parameter bit STORE_EOI_EN = 1'b1,
   parameter bit TRIG_PAGE_EN = 1'b1,
   localparam int SRC_W       = $clog2(NUM_SRC),
   localparam int ADDR_W      = PAGE_SHIFT + SRC_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] hw_trig,
   input  logic               bus_req,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   output logic [63:0]        bus_rdata,
   output logic               bus_rvalid,
   output logic               evt_valid,
   output logic [SRC_W-1:0]   evt_src
);
   if (NUM_SRC < 2) begin : g_bad_num
      $error("pq_coalesce: NUM_SRC must be at least 2");
   end
   if (PAGE_SHIFT < 12) begin : g_bad_page
      $error("pq_coalesce: PAGE_SHIFT must be at least 12");
   end

   pq_op_e               dec_op;
   logic [SRC_W-1:0]     dec_src;
   logic [1:0]           dec_set;
   logic [NUM_SRC-1:0]   fwd, grant;
   logic [1:0]           pq_arr [NUM_SRC];
   logic [2*NUM_SRC-1:0] pq_flat;
   logic [1:0]           old_pq;
   logic                 rd_hit;

   pq_decode #(
      .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT),
      .STORE_EOI_EN(STORE_EOI_EN), .TRIG_PAGE_EN(TRIG_PAGE_EN)
   ) u_dec (
      .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .op(dec_op), .src(dec_src), .set_val(dec_set)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic sel_i;
      assign sel_i = (dec_op != OP_NONE) && (dec_src == SRC_W'(i));
      pq_cell u_cell (
         .clk(clk), .rst_n(rst_n), .sel(sel_i), .op(dec_op),
         .set_val(dec_set), .hw_trig(hw_trig[i]), .emit_clr(grant[i]),
         .pq(pq_arr[i]), .fwd(fwd[i])
      );
      assign pq_flat[2*i +: 2] = pq_arr[i];
   end

   pq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .fwd(fwd), .valid(evt_valid), .idx(evt_src), .grant(grant)
   );

   assign rd_hit = (dec_op == OP_GET) || (dec_op == OP_SET);
   assign old_pq = rd_hit ? pq_arr[dec_src] : 2'b00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_req && !bus_wr;
         bus_rdata  <= {62'd0, old_pq};
      end
   end
endmodule

// File: rtl/pq_coalesce_chk.sv
module pq_coalesce_chk #(
   parameter int NUM_SRC = 8,
   localparam int SRC_W  = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] hw_trig,
   input logic               bus_req,
   input logic               bus_wr,
   input logic [63:0]        bus_rdata,
   input logic               bus_rvalid,
   input logic               evt_valid,
   input logic [SRC_W-1:0]   evt_src,
   input logic [2*NUM_SRC-1:0] pq_flat
);
   p_rvalid_after_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr) |=> bus_rvalid);

   p_rvalid_only_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_wr) |=> !bus_rvalid);

   p_rdata_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rvalid |-> (bus_rdata == '0));

   p_rdata_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[63:2] == '0);

   p_event_needs_p_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> pq_flat[{evt_src, 1'b1}]);

   p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req && hw_trig == '0) |=> $stable(pq_flat));
endmodule

bind pq_coalesce pq_coalesce_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .bus_req(bus_req),
   .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
   .evt_valid(evt_valid), .evt_src(evt_src), .pq_flat(pq_flat)
);

// File: tb/tb_pq_coalesce.sv
`timescale 1ns/1ps
module tb_pq_coalesce;
   localparam int N  = 8;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  hw_trig = '0;
   logic          bus_req = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [63:0]   bus_rdata;
   logic          bus_rvalid;
   logic          evt_valid;
   logic [2:0]    evt_src;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pq_coalesce dut (
      .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .bus_req(bus_req),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .evt_valid(evt_valid), .evt_src(evt_src)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // kind: 0 load at offset, 1 store-EOI, 2 trigger-page store, 3 hw trigger only
   task automatic step(input int kind, input int src, input logic [11:0] off,
                       input logic [N-1:0] hwm, input logic [1:0] exp_rd,
                       input bit exp_ev, input int exp_src, input string tag);
      @(negedge clk);
      bus_req = (kind != 3);
      bus_wr  = (kind == 1) || (kind == 2);
      case (kind)
         0: bus_addr = {1'b0, 3'(src), off};
         1: bus_addr = {1'b0, 3'(src), 12'h000};
         2: bus_addr = {1'b1, 3'(src), 12'h000};
         default: bus_addr = '0;
      endcase
      hw_trig = hwm;
      @(posedge clk);
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0; hw_trig = '0;
      chk(bus_rvalid == (kind == 0), {tag, " R13 rvalid"}, bus_rvalid, kind == 0);
      if (kind == 0)
         chk(bus_rdata == {62'd0, exp_rd}, {tag, " rdata"}, bus_rdata, exp_rd);
      chk(evt_valid == exp_ev, {tag, " evt_valid"}, evt_valid, exp_ev);
      if (exp_ev)
         chk(evt_src == 3'(exp_src), {tag, " evt_src"}, evt_src, exp_src);
   endtask

   // {kind[1:0], src[2:0], off[11:0], exp_rd[1:0], exp_ev, exp_src[2:0]}
   localparam int NV = 20;
   localparam logic [22:0] VEC [NV] = '{
      {2'd0, 3'd2, 12'h800, 2'b00, 1'b0, 3'd0},  // R2 read idle
      {2'd3, 3'd2, 12'h000, 2'b00, 1'b1, 3'd2},  // R4 first trigger
      {2'd0, 3'd2, 12'h800, 2'b10, 1'b0, 3'd0},  // R2 P set
      {2'd3, 3'd2, 12'h000, 2'b00, 1'b0, 3'd0},  // R5 folded
      {2'd0, 3'd2, 12'h800, 2'b11, 1'b0, 3'd0},  // R5 Q set
      {2'd1, 3'd2, 12'h000, 2'b00, 1'b1, 3'd2},  // R6 re-fire
      {2'd0, 3'd2, 12'h800, 2'b10, 1'b0, 3'd0},  // R6 state 10
      {2'd1, 3'd2, 12'h000, 2'b00, 1'b0, 3'd0},  // R6 plain EOI
      {2'd0, 3'd2, 12'h800, 2'b00, 1'b0, 3'd0},  // R6 state 00
      {2'd2, 3'd5, 12'h000, 2'b00, 1'b1, 3'd5},  // R7 trigger page
      {2'd2, 3'd5, 12'h000, 2'b00, 1'b0, 3'd0},  // R7 folded
      {2'd0, 3'd5, 12'hC00, 2'b11, 1'b0, 3'd0},  // R3 set 00
      {2'd0, 3'd5, 12'hD00, 2'b00, 1'b0, 3'd0},  // R3 R12 set 01
      {2'd0, 3'd5, 12'hF00, 2'b01, 1'b0, 3'd0},  // R3 R12 set 11
      {2'd0, 3'd5, 12'hE00, 2'b11, 1'b0, 3'd0},  // R3 R12 set 10
      {2'd0, 3'd5, 12'h900, 2'b00, 1'b0, 3'd0},  // R11 other offset
      {2'd0, 3'd5, 12'h800, 2'b10, 1'b0, 3'd0},  // R11 unchanged
      {2'd1, 3'd5, 12'h000, 2'b00, 1'b0, 3'd0},  // R6 clean up
      {2'd0, 3'd7, 12'hE00, 2'b00, 1'b0, 3'd0},  // R3 R12 no event
      {2'd0, 3'd7, 12'h800, 2'b10, 1'b0, 3'd0}   // R3 read back
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!evt_valid, "R1 evt_valid", evt_valid, 0);
      chk(!bus_rvalid, "R1 rvalid", bus_rvalid, 0);
      for (int s = 0; s < N; s++) step(0, s, 12'h800, '0, 2'b00, 0, 0, "R1 reset state");

      // vector table
      for (int v = 0; v < NV; v++) begin
         logic [22:0] e;
         e = VEC[v];
         step(int'(e[22:21]), int'(e[20:18]), e[17:6],
              (e[22:21] == 2'd3) ? (N'(1) << e[20:18]) : '0,
              e[5:4], e[3], int'(e[2:0]), $sformatf("vector %0d", v));
      end

      // R9 trigger lands after a same-cycle software overwrite
      step(0, 4, 12'hF00, '0, 2'b00, 0, 0, "R9 prep");
      step(0, 4, 12'hC00, N'(1) << 4, 2'b11, 1, 4, "R9 clear with trigger");
      step(0, 4, 12'h800, '0, 2'b10, 0, 0, "R9 state after");
      step(1, 4, 12'h000, '0, 2'b00, 0, 0, "R9 clean up");

      // R10 simultaneous events, lowest first
      @(negedge clk);
      hw_trig = 8'b0100_1010;
      @(posedge clk);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         hw_trig = '0;
         if (k < 3) begin
            int exp;
            exp = (k == 0) ? 1 : (k == 1) ? 3 : 6;
            chk(evt_valid && evt_src == 3'(exp), "R10 order", {evt_valid, evt_src}, {1'b1, 3'(exp)});
         end else begin
            chk(!evt_valid, "R10 drained", evt_valid, 0);
         end
      end
      step(1, 1, 12'h000, '0, 2'b00, 0, 0, "R10 clean 1");
      step(1, 3, 12'h000, '0, 2'b00, 0, 0, "R10 clean 3");
      step(1, 6, 12'h000, '0, 2'b00, 0, 0, "R10 clean 6");

      // R8 held trigger gives one event
      begin
         int cnt;
         cnt = 0;
         for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (evt_valid && evt_src == 3'd0) cnt++;
            hw_trig = (i < 5) ? N'(1) : '0;
         end
         chk(cnt == 1, "R8 single event", cnt, 1);
      end
      step(0, 0, 12'h800, '0, 2'b11, 0, 0, "R8 state 11");
      step(1, 0, 12'h000, '0, 2'b00, 1, 0, "R8 R6 re-fire");
      step(1, 0, 12'h000, '0, 2'b00, 0, 0, "R8 final EOI");
      step(0, 0, 12'h800, '0, 2'b00, 0, 0, "R8 back to 00");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule